// File: doc/BRIEF.md
# ADC Result Buffer with Sticky Error Flags

This block sits between an analog-to-digital converter and an 8-bit host register bus. Each finished conversion delivers a 16-bit result. The block stores these results in order in a small FIFO. The host drains the FIFO one byte at a time through a single data register. The host polls a status byte, which shows whether data is waiting. The status byte also carries two error flags. The first error flag records that a result was lost because the FIFO was full. The second records that a conversion was started while the previous one was still running. Both flags hold their value until software clears them.

On the converter side, results arrive on a valid/ready interface. The converter cannot be stalled, so `res_ready` only reports room in the FIFO. A result presented while `res_ready` is low is dropped and counted as an overflow. It is not held back.

Start pulses from the converter count only after software has armed the trigger bit in the command register. A write of any value to the clear register does three things in one cycle: it flushes the FIFO, lowers both error flags and puts the byte sequencer back to the low byte.

Top module: `adc_result_buffer`

## Requirements
- R1: After reset the status byte reads 0x00, `res_ready` is 1, the FIFO is empty and the trigger is disarmed.
- R2: Status bit 0 (data-available) is 1 exactly when the FIFO holds at least one unread result.
- R3: A read of the data register (address 1) returns bits 7:0 of the oldest result. The next read returns bits 15:8 and removes that result, so results leave in arrival order.
- R4: The FIFO holds DEPTH (16) results. `res_ready` is 0 exactly while it is full.
- R5: A result presented while the FIFO is full is discarded and sets status bit 1 (overflow). The bit stays set until a clear write, even after the FIFO drains.
- R6: With the trigger armed, a `conv_start` pulse sets status bit 2 (overrun) when an earlier accepted start has had no result since. This holds only if no result arrives in that same cycle. The bit stays set until a clear write.
- R7: `conv_start` is ignored while command-register bit 0 is 0. Address 3 is the command register: writes set it and reads return the last byte written.
- R8: A write to address 2, with any data, empties the FIFO, clears status bits 1 and 2, and sets the next data read to a low byte.
- R9: When a clear write and an incoming result happen in the same cycle, the result is discarded and no overflow is recorded.
- R10: A data-register read while the FIFO is empty returns 0x00 and changes neither the FIFO nor the byte phase.
- R11: Status bits 7:3 read as 0. Reading the status register (address 0) has no side effect. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | One-cycle pulse: the converter began a conversion |
| res_valid | input | 1 | A conversion result is present this cycle (ends the conversion) |
| res_ready | output | 1 | FIFO has room; a result with this low is dropped |
| res_data | input | 16 | Conversion result |
| bus_addr | input | 2 | Register select: 0 status, 1 data, 2 clear, 3 command |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |

## Verification
The bench builds the block with its defaults: DEPTH of 16 and a 16-bit result, read as two bytes. With these values the full boundary is reached after sixteen results, so the bench can fill the FIFO completely, drop a seventeenth result and drain all entries again in a few hundred cycles. A two-byte result also lets the bench interrupt a pair after the low byte, which tests the reset of the byte phase. Each cycle, a queue-based model predicts `bus_rdata` and `res_ready`, and the bench compares both against the design.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_DATA   = 2'd1,
    REG_CLEAR  = 2'd2,
    REG_CMD    = 2'd3
  } reg_addr_e;

  localparam int unsigned STAT_DAVAIL = 0;
  localparam int unsigned STAT_OVF    = 1;
  localparam int unsigned STAT_OVR    = 2;
  localparam int unsigned CMD_TRIG    = 0;
endpackage

// File: rtl/adc_res_fifo.sv
module adc_res_fifo #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic [CW-1:0]     fill
);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign empty   = (fill == '0);
  assign full    = (fill == FULL_CNT);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/adc_err_flags.sv
module adc_err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic ovf_evt,
  input  logic ovr_evt,
  output logic ovf,
  output logic ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      ovr <= 1'b0;
    end else if (clear) begin
      ovf <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (ovf_evt) ovf <= 1'b1;
      if (ovr_evt) ovr <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_byte_seq.sv
module adc_byte_seq #(
  parameter int unsigned NBYTES = 2,
  localparam int unsigned BW    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [BW-1:0] idx,
  output logic          last
);
  generate
    if (NBYTES == 1) begin : g_single
      assign idx  = '0;
      assign last = 1'b1;
    end else begin : g_multi
      localparam logic [BW-1:0] LAST_IDX = BW'(NBYTES - 1);
      logic [BW-1:0] idx_q;
      assign idx  = idx_q;
      assign last = (idx_q == LAST_IDX);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        idx_q <= '0;
        else if (clear)    idx_q <= '0;
        else if (advance)  idx_q <= last ? '0 : idx_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/adc_result_buffer.sv
module adc_result_buffer #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NBYTES = DATA_W / 8,
  localparam int unsigned BW     = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  input  logic [1:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  import adc_buf_pkg::*;

  logic              clear_wr, cmd_wr, data_rd;
  logic              empty, full, pop, last;
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     fill_w;
  logic [BW-1:0]     byte_idx;
  logic              ovf, ovr, ovf_evt, ovr_evt;
  logic              start_ok, busy;
  logic [7:0]        cmd_q;
  logic [7:0]        status_w;
  logic [7:0]        head_byte;

  assign clear_wr  = bus_wr && (bus_addr == REG_CLEAR);
  assign cmd_wr    = bus_wr && (bus_addr == REG_CMD);
  assign data_rd   = bus_rd && (bus_addr == REG_DATA) && !empty && !clear_wr;
  assign pop       = data_rd && last;
  assign res_ready = !full;

  assign start_ok  = conv_start && cmd_q[CMD_TRIG];
  assign ovf_evt   = res_valid && full && !clear_wr;
  assign ovr_evt   = start_ok && busy && !res_valid;

  adc_res_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (clear_wr),
    .push      (res_valid),
    .push_data (res_data),
    .pop       (pop),
    .head      (head),
    .empty     (empty),
    .full      (full),
    .fill      (fill_w)
  );

  adc_byte_seq #(.NBYTES(NBYTES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear_wr),
    .advance (data_rd),
    .idx     (byte_idx),
    .last    (last)
  );

  adc_err_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear_wr),
    .ovf_evt (ovf_evt),
    .ovr_evt (ovr_evt),
    .ovf     (ovf),
    .ovr     (ovr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      busy  <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= bus_wdata;
      if (start_ok)       busy <= 1'b1;
      else if (res_valid) busy <= 1'b0;
    end
  end

  always_comb begin
    status_w              = '0;
    status_w[STAT_DAVAIL] = !empty;
    status_w[STAT_OVF]    = ovf;
    status_w[STAT_OVR]    = ovr;
  end

  assign head_byte = head[byte_idx*8 +: 8];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        REG_STATUS: bus_rdata = status_w;
        REG_DATA:   bus_rdata = empty ? 8'h00 : head_byte;
        REG_CMD:    bus_rdata = cmd_q;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_result_buffer_chk.sv
module adc_result_buffer_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic          res_valid,
  input logic          res_ready,
  input logic [7:0]    status_w,
  input logic [CW-1:0] fill_w
);
  logic clr;
  assign clr = bus_wr && (bus_addr == 2'd2);

  // R2
  davail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[0] == (fill_w != '0));

  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_w <= CW'(DEPTH)) && (res_ready == (fill_w != CW'(DEPTH))));

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready && !clr |=> status_w[1]);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[1] && !clr |=> status_w[1]);

  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[2] && !clr |=> status_w[2]);

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (status_w[2:0] == 3'b000) && (fill_w == '0));

  // R10
  empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr == 2'd1) && (fill_w == '0) && !res_valid |=> fill_w == '0);

  // R11
  status_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[7:3] == 5'b0);
endmodule

bind adc_result_buffer adc_result_buffer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .status_w  (status_w),
  .fill_w    (fill_w)
);

// File: tb/adc_result_buffer_bench.sv
module adc_result_buffer_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0, res_valid = 1'b0, res_ready;
  logic [15:0] res_data = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata;

  always #10 clk = ~clk;

  adc_result_buffer #(.DEPTH(DEPTH), .DATA_W(16)) u_adc_result_buffer (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [15:0] q[$];
  bit m_ovf = 0, m_ovr = 0, m_hi = 0, m_busy = 0;
  logic [7:0] m_cmd = 0;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata(input bit rd, input logic [1:0] a);
    if (!rd) return 8'h00;
    case (a)
      2'd0: return {5'b0, m_ovr, m_ovf, q.size() != 0};
      2'd1: return (q.size() == 0) ? 8'h00 : (m_hi ? q[0][15:8] : q[0][7:0]);
      2'd3: return m_cmd;
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input bit rd, input bit wr, input logic [1:0] a, input logic [7:0] wd,
                      input bit sv, input logic [15:0] sd, input bit st, input string tag);
    bit clr, full_pre, trig;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    res_valid = sv; res_data = sd; conv_start = st;
    #2;
    check(bus_rdata == exp_rdata(rd, a), tag, {8'h0, bus_rdata}, {8'h0, exp_rdata(rd, a)});
    check(res_ready == (q.size() < DEPTH), "R4", {15'b0, res_ready}, {15'b0, q.size() < DEPTH});
    @(posedge clk);
    clr = wr && a == 2'd2;
    full_pre = (q.size() == DEPTH);
    trig = m_cmd[0];
    if (clr) begin
      q.delete(); m_ovf = 0; m_ovr = 0; m_hi = 0;
    end else begin
      if (rd && a == 2'd1 && q.size() != 0) begin
        if (m_hi) void'(q.pop_front());
        m_hi = !m_hi;
      end
      if (sv && !full_pre) q.push_back(sd);
      if (sv && full_pre) m_ovf = 1;
      if (st && trig && m_busy && !sv) m_ovr = 1;
    end
    if (wr && a == 2'd3) m_cmd = wd;
    if (st && trig) m_busy = 1;
    else if (sv) m_busy = 0;
  endtask

  task automatic idle(input string tag);        step(0, 0, 0, 0, 0, 0, 0, tag); endtask
  task automatic rd_reg(input logic [1:0] a, input string tag); step(1, 0, a, 0, 0, 0, 0, tag); endtask
  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d, input string tag); step(0, 1, a, d, 0, 0, 0, tag); endtask
  task automatic put(input logic [15:0] d, input string tag); step(0, 0, 0, 0, 1, d, 0, tag); endtask
  task automatic start(input string tag);       step(0, 0, 0, 0, 0, 0, 1, tag); endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd_reg(0, "R1");
    rd_reg(3, "R1");
    // R10 empty data read
    rd_reg(1, "R10");
    rd_reg(1, "R10");
    rd_reg(0, "R10");
    // R7 starts ignored while disarmed
    start("R7"); start("R7");
    rd_reg(0, "R7");
    wr_reg(3, 8'h81, "R7");
    rd_reg(3, "R7");
    // R6 overrun
    start("R6"); start("R6");
    rd_reg(0, "R6");
    put(16'hBEEF, "R2");
    rd_reg(0, "R2");
    rd_reg(1, "R3"); rd_reg(1, "R3");
    rd_reg(0, "R6");
    // R8 clear with arbitrary data
    wr_reg(2, 8'hA5, "R8");
    rd_reg(0, "R8");
    // R6 start with same-cycle result is not an overrun
    start("R6");
    step(0, 0, 0, 0, 1, 16'h1234, 1, "R6");
    rd_reg(0, "R6");
    rd_reg(1, "R3"); rd_reg(1, "R3");
    put(16'h5601, "R3"); put(16'h5602, "R3");
    rd_reg(1, "R3");
    put(16'h5603, "R3");
    rd_reg(1, "R3"); rd_reg(1, "R3"); rd_reg(1, "R3");
    rd_reg(1, "R3"); rd_reg(1, "R3"); rd_reg(1, "R3");
    rd_reg(0, "R2");
    // R4/R5 fill, overflow, drain
    for (int i = 0; i < DEPTH; i++) put(16'(i * 16'h0731 + 16'h0102), "R4");
    rd_reg(0, "R4");
    put(16'hDEAD, "R5");
    rd_reg(0, "R5");
    // R11 status reads have no side effect
    rd_reg(0, "R11"); rd_reg(0, "R11"); rd_reg(2, "R11");
    step(0, 0, 1, 0, 0, 0, 0, "R11");
    for (int i = 0; i < 2 * DEPTH; i++) rd_reg(1, "R5");
    rd_reg(0, "R5");
    rd_reg(1, "R10");
    // R8 clear mid-pair resets byte phase
    put(16'hA1B2, "R8"); put(16'hC3D4, "R8");
    rd_reg(1, "R8");
    wr_reg(2, 8'h00, "R8");
    put(16'hE5F6, "R8");
    rd_reg(1, "R8"); rd_reg(1, "R8");
    rd_reg(0, "R8");
    // R9 clear beats same-cycle result
    put(16'h7788, "R9");
    step(0, 1, 2, 8'h3C, 1, 16'h99AA, 0, "R9");
    rd_reg(0, "R9");
    rd_reg(1, "R9");
    idle("R11");
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule